// File: doc/BRIEF.md
# Debug Halt and Instruction Injection Controller

This block decides when the processor core is frozen for debug. Thirteen exception event lines, each gated by its own bit of a stop-enable vector, a breakpoint request line and a host control write can all drive the core into the halted state. A host debug-disable line overrides every one of them. Each exception event records, in a per-source reason register, whether that source was allowed to stop the core. The reason bits stay until the host overwrites them.

The host can also hand the core a single instruction to run while it is halted. An instruction written while the core is halted, with the host core-reset bit low, goes to the fetch stage at once through a valid/ready handshake. An instruction written while the core runs, or while the reset bit is high, waits as pending. It is offered once the core is halted and reset is released. The instruction register is write-only: a read attempt returns an access-error pulse. When a host control write takes the reset bit from high to low, the block emits a one-cycle core reset pulse.

Two state machines form the core of the block. The halt machine has two states. RUN goes to STOP on an enabled exception, a breakpoint or a host stall write. STOP goes back to RUN on a host release write with no trigger present. Debug-disable forces RUN from either state. The injection machine has three states. IDLE goes to ISSUE on a write when the core is halted and reset is released, and to PEND on any other write. PEND goes to ISSUE once the core is halted and reset is released. ISSUE goes back to IDLE on the fetch-stage accept.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, cpu_stall, reason, cpu_rst_pulse, inj_rd_err and inj_valid are all 0.
- R2: Exception source bit order in exc_evt, stop_en and reason is: 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 low-priority interrupt, 5 alignment, 6 illegal instruction, 7 high-priority interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 break. One cycle after exc_evt[i] is high, reason[i] equals stop_en[i] as sampled in that cycle. Bits of sources without an event are unchanged.
- R3: One cycle after an exception whose stop_en bit is 1, cpu_stall is 1. An exception whose stop_en bit is 0 leaves cpu_stall unchanged.
- R4: One cycle after bkpt_req is high, cpu_stall is 1.
- R5: One cycle after ctl_wr, cpu_stall equals ctl_stall. If a trigger (enabled exception or breakpoint) is present in the same cycle, the trigger wins and cpu_stall is 1.
- R6: One cycle after dbg_disable is high, cpu_stall is 0, whatever the triggers and host writes.
- R7: reason keeps its value until rsn_wr, which loads rsn_wdata one cycle later. In the same cycle, a bit whose exception event is high takes stop_en instead.
- R8: inj_wr while cpu_stall is 1 and the reset bit is 0 raises inj_valid one cycle later, with inj_insn equal to the written word.
- R9: inj_wr while cpu_stall is 0 leaves inj_valid at 0. inj_valid rises one cycle after cpu_stall rises.
- R10: While the host reset bit (ctl_reset as last written by ctl_wr) is 1, a written instruction is not offered. It is offered one cycle after the reset bit reads 0 with the core halted.
- R11: A ctl_wr that takes the reset bit from 1 to 0 makes cpu_rst_pulse high for exactly the one following cycle.
- R12: inj_valid and inj_insn hold until inj_ready is high. inj_valid is 0 one cycle after the accept. An inj_wr while inj_valid is high is ignored.
- R13: inj_rd gives an inj_rd_err pulse of one cycle, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_evt | input | 13 | Exception event lines, one per source |
| stop_en | input | 13 | Per-source stop-enable bits |
| bkpt_req | input | 1 | Breakpoint stop request |
| dbg_disable | input | 1 | Forces the core to run |
| ctl_wr | input | 1 | Host control register write strobe |
| ctl_stall | input | 1 | Host stall bit of the control write |
| ctl_reset | input | 1 | Host core-reset bit of the control write |
| rsn_wr | input | 1 | Host write strobe for the reason register |
| rsn_wdata | input | 13 | Reason register write data |
| inj_wr | input | 1 | Injection register write strobe |
| inj_wdata | input | 32 | Instruction word to inject |
| inj_rd | input | 1 | Read attempt on the injection register |
| inj_ready | input | 1 | Fetch stage accepts the offered instruction |
| cpu_stall | output | 1 | Registered core halt |
| reason | output | 13 | Debug reason register |
| cpu_rst_pulse | output | 1 | One-cycle core reset pulse |
| inj_rd_err | output | 1 | Access-error pulse for an injection read |
| inj_valid | output | 1 | Injected instruction offered to fetch |
| inj_insn | output | 32 | Injected instruction word |

## Verification
Every result is registered. cpu_stall, reason, cpu_rst_pulse and inj_rd_err are therefore due at the first clock edge after the cycle that carries the stimulus. A pending instruction needs one edge more: the halt state must be registered before the injection machine sees it. The bench drives inputs just after a rising edge. It samples one nanosecond after the next edge, and it steps one extra edge for the pending-to-offer and reset-release cases. It samples again one edge later to confirm that pulses last a single cycle and that offered data stays stable while the fetch stage is not ready.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int EXC_COUNT = 13;

    // Source bit positions in the event, enable and reason vectors
    localparam int EXC_RESET    = 0;
    localparam int EXC_BUSERR   = 1;
    localparam int EXC_DPAGE    = 2;
    localparam int EXC_IPAGE    = 3;
    localparam int EXC_LOINT    = 4;
    localparam int EXC_ALIGN    = 5;
    localparam int EXC_ILLEGAL  = 6;
    localparam int EXC_HIINT    = 7;
    localparam int EXC_DTLB     = 8;
    localparam int EXC_ITLB     = 9;
    localparam int EXC_RANGE    = 10;
    localparam int EXC_SYSCALL  = 11;
    localparam int EXC_BREAK    = 12;

    typedef enum logic {
        HALT_RUN  = 1'b0,
        HALT_STOP = 1'b1
    } halt_state_t;

    typedef enum logic [1:0] {
        INJ_IDLE  = 2'd0,
        INJ_PEND  = 2'd1,
        INJ_ISSUE = 2'd2
    } inj_state_t;

endpackage

// File: rtl/dbg_reason_reg.sv
module dbg_reason_reg #(
    parameter int NEXC = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXC-1:0] exc_evt,
    input  logic [NEXC-1:0] stop_en,
    input  logic            wr,
    input  logic [NEXC-1:0] wdata,
    output logic [NEXC-1:0] reason
);

    logic [NEXC-1:0] bits_q;

    for (genvar i = 0; i < NEXC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
            end else if (exc_evt[i]) begin
                bits_q[i] <= stop_en[i];
            end else if (wr) begin
                bits_q[i] <= wdata[i];
            end
        end
    end

    assign reason = bits_q;

    AST_REASON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|exc_evt) && !wr) |=> $stable(reason)); // R7

    AST_REASON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(|exc_evt)) |=> (reason == $past(wdata))); // R7

endmodule

// File: rtl/dbg_stall_fsm.sv
module dbg_stall_fsm
    import dbg_halt_pkg::*;
#(
    parameter int NEXC = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXC-1:0] exc_evt,
    input  logic [NEXC-1:0] stop_en,
    input  logic            bkpt_req,
    input  logic            dbg_disable,
    input  logic            ctl_wr,
    input  logic            ctl_stall,
    input  logic            ctl_reset,
    output logic            stalled,
    output logic            rst_hold,
    output logic            rst_pulse
);

    halt_state_t state_q, state_d;
    logic        rst_bit_q;
    logic        pulse_q;
    logic        trig;

    assign trig = (|(exc_evt & stop_en)) | bkpt_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALT_RUN: begin
                if (trig || (ctl_wr && ctl_stall)) begin
                    state_d = HALT_STOP;
                end
            end
            HALT_STOP: begin
                if (ctl_wr && !ctl_stall && !trig) begin
                    state_d = HALT_RUN;
                end
            end
            default: state_d = HALT_RUN;
        endcase
        if (dbg_disable) begin
            state_d = HALT_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HALT_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Host reset bit and its falling-edge pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_bit_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= ctl_wr && rst_bit_q && !ctl_reset;
            if (ctl_wr) begin
                rst_bit_q <= ctl_reset;
            end
        end
    end

    always_comb begin
        stalled   = (state_q == HALT_STOP);
        rst_hold  = rst_bit_q;
        rst_pulse = pulse_q;
    end

    AST_DISABLE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_disable |=> !stalled); // R6

    AST_BKPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_req && !dbg_disable) |=> stalled); // R4

    AST_EXC_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(exc_evt & stop_en)) && !dbg_disable) |=> stalled); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse); // R11

endmodule

// File: rtl/dbg_inject_fsm.sv
module dbg_inject_fsm
    import dbg_halt_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stalled,
    input  logic          rst_hold,
    input  logic          inj_wr,
    input  logic [IW-1:0] inj_wdata,
    input  logic          inj_rd,
    input  logic          inj_ready,
    output logic          inj_valid,
    output logic [IW-1:0] inj_insn,
    output logic          inj_rd_err
);

    inj_state_t    state_q, state_d;
    logic [IW-1:0] insn_q;
    logic          err_q;
    logic          can_issue;
    logic          load;

    assign can_issue = stalled && !rst_hold;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            INJ_IDLE: begin
                if (inj_wr) begin
                    load    = 1'b1;
                    state_d = can_issue ? INJ_ISSUE : INJ_PEND;
                end
            end
            INJ_PEND: begin
                load = inj_wr;
                if (can_issue) begin
                    state_d = INJ_ISSUE;
                end
            end
            INJ_ISSUE: begin
                if (inj_ready) begin
                    state_d = INJ_IDLE;
                end
            end
            default: state_d = INJ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INJ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= inj_rd;
            if (load) begin
                insn_q <= inj_wdata;
            end
        end
    end

    always_comb begin
        inj_valid  = (state_q == INJ_ISSUE);
        inj_insn   = insn_q;
        inj_rd_err = err_q;
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_ready) |=> (inj_valid && $stable(inj_insn))); // R12

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && inj_ready) |=> !inj_valid); // R12

    AST_NO_ISSUE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_valid && rst_hold) |=> !inj_valid); // R10

    AST_RD_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        inj_rd |=> inj_rd_err); // R13

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int NEXC = EXC_COUNT,
    parameter int IW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXC-1:0] exc_evt,
    input  logic [NEXC-1:0] stop_en,
    input  logic            bkpt_req,
    input  logic            dbg_disable,
    input  logic            ctl_wr,
    input  logic            ctl_stall,
    input  logic            ctl_reset,
    input  logic            rsn_wr,
    input  logic [NEXC-1:0] rsn_wdata,
    input  logic            inj_wr,
    input  logic [IW-1:0]   inj_wdata,
    input  logic            inj_rd,
    input  logic            inj_ready,
    output logic            cpu_stall,
    output logic [NEXC-1:0] reason,
    output logic            cpu_rst_pulse,
    output logic            inj_rd_err,
    output logic            inj_valid,
    output logic [IW-1:0]   inj_insn
);

    logic stalled;
    logic rst_hold;

    dbg_stall_fsm #(.NEXC(NEXC)) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_evt     (exc_evt),
        .stop_en     (stop_en),
        .bkpt_req    (bkpt_req),
        .dbg_disable (dbg_disable),
        .ctl_wr      (ctl_wr),
        .ctl_stall   (ctl_stall),
        .ctl_reset   (ctl_reset),
        .stalled     (stalled),
        .rst_hold    (rst_hold),
        .rst_pulse   (cpu_rst_pulse)
    );

    dbg_reason_reg #(.NEXC(NEXC)) u_reason (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc_evt (exc_evt),
        .stop_en (stop_en),
        .wr      (rsn_wr),
        .wdata   (rsn_wdata),
        .reason  (reason)
    );

    dbg_inject_fsm #(.IW(IW)) u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .stalled    (stalled),
        .rst_hold   (rst_hold),
        .inj_wr     (inj_wr),
        .inj_wdata  (inj_wdata),
        .inj_rd     (inj_rd),
        .inj_ready  (inj_ready),
        .inj_valid  (inj_valid),
        .inj_insn   (inj_insn),
        .inj_rd_err (inj_rd_err)
    );

    assign cpu_stall = stalled;

    AST_OFFER_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_valid) |-> $past(cpu_stall)); // R9

endmodule

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;

    localparam int PERIOD = 10;
    localparam int NEXC   = 13;
    localparam int IW     = 32;
    localparam logic [NEXC-1:0] ALL1 = '1;

    // vector: {code[3:0], enable, expected stall}
    localparam int NVEC = 8;
    localparam logic [5:0] VEC [NVEC] = '{
        {4'd0,  1'b1, 1'b1},
        {4'd1,  1'b0, 1'b0},
        {4'd4,  1'b1, 1'b1},
        {4'd6,  1'b0, 1'b0},
        {4'd7,  1'b1, 1'b1},
        {4'd9,  1'b0, 1'b0},
        {4'd11, 1'b1, 1'b1},
        {4'd12, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NEXC-1:0] exc_evt = '0, stop_en = '0, rsn_wdata = '0;
    logic bkpt_req = 0, dbg_disable = 0, ctl_wr = 0, ctl_stall = 0, ctl_reset = 0;
    logic rsn_wr = 0, inj_wr = 0, inj_rd = 0, inj_ready = 0;
    logic [IW-1:0] inj_wdata = '0;
    logic cpu_stall, cpu_rst_pulse, inj_rd_err, inj_valid;
    logic [NEXC-1:0] reason;
    logic [IW-1:0] inj_insn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    dbg_halt_ctrl #(.NEXC(NEXC), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .stop_en(stop_en),
        .bkpt_req(bkpt_req), .dbg_disable(dbg_disable), .ctl_wr(ctl_wr),
        .ctl_stall(ctl_stall), .ctl_reset(ctl_reset), .rsn_wr(rsn_wr),
        .rsn_wdata(rsn_wdata), .inj_wr(inj_wr), .inj_wdata(inj_wdata),
        .inj_rd(inj_rd), .inj_ready(inj_ready), .cpu_stall(cpu_stall),
        .reason(reason), .cpu_rst_pulse(cpu_rst_pulse), .inj_rd_err(inj_rd_err),
        .inj_valid(inj_valid), .inj_insn(inj_insn)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        exc_evt = '0; stop_en = '0; bkpt_req = 0; dbg_disable = 0;
        ctl_wr = 0; rsn_wr = 0; inj_wr = 0; inj_rd = 0; inj_ready = 0;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_ctl(input logic st, input logic rs);
        ctl_wr = 1; ctl_stall = st; ctl_reset = rs;
        tick();
        ctl_wr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk({cpu_stall, reason, cpu_rst_pulse, inj_rd_err, inj_valid} == '0, "R1",
            {cpu_stall, cpu_rst_pulse, inj_rd_err, inj_valid, 15'(reason)}, 0);

        // R2/R3 exception table
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] code;
            logic en, exp_st;
            logic [NEXC-1:0] onehot, exp_r;
            {code, en, exp_st} = VEC[v];
            onehot = NEXC'(1) << code;
            ctl_wr = 1; ctl_stall = 0; ctl_reset = 0; rsn_wr = 1; rsn_wdata = ALL1;
            tick();
            ctl_wr = 0; rsn_wr = 0;
            exc_evt = onehot;
            stop_en = en ? onehot : ~onehot;
            tick();
            exc_evt = '0; stop_en = '0;
            exp_r = en ? ALL1 : (ALL1 & ~onehot);
            chk(reason == exp_r, "R2", 32'(reason), 32'(exp_r));
            chk(cpu_stall == exp_st, "R3", 32'(cpu_stall), 32'(exp_st));
        end

        // R3 disabled exception leaves a halted core halted
        host_ctl(1, 0);
        exc_evt = 13'h0004; stop_en = 13'h0000;
        tick();
        idle_inputs();
        chk(cpu_stall == 1, "R3", 32'(cpu_stall), 1);

        // R5 host release, then trigger beats a release in the same cycle
        host_ctl(0, 0);
        chk(cpu_stall == 0, "R5", 32'(cpu_stall), 0);
        ctl_wr = 1; ctl_stall = 0; bkpt_req = 1;
        tick();
        idle_inputs();
        chk(cpu_stall == 1, "R5", 32'(cpu_stall), 1);

        // R4 breakpoint
        host_ctl(0, 0);
        bkpt_req = 1;
        tick();
        idle_inputs();
        chk(cpu_stall == 1, "R4", 32'(cpu_stall), 1);

        // R6 disable overrides halt, breakpoint and host stall
        dbg_disable = 1;
        tick();
        chk(cpu_stall == 0, "R6", 32'(cpu_stall), 0);
        bkpt_req = 1; ctl_wr = 1; ctl_stall = 1;
        tick();
        idle_inputs();
        chk(cpu_stall == 0, "R6", 32'(cpu_stall), 0);

        // R7 hold, write, event priority
        rsn_wr = 1; rsn_wdata = 13'h0A5A;
        tick();
        idle_inputs();
        chk(reason == 13'h0A5A, "R7", 32'(reason), 32'h0A5A);
        tick(); tick();
        chk(reason == 13'h0A5A, "R7", 32'(reason), 32'h0A5A);
        rsn_wr = 1; rsn_wdata = 13'h0000; exc_evt = 13'h1000; stop_en = 13'h1000;
        tick();
        idle_inputs();
        chk(reason == 13'h1000, "R7", 32'(reason), 32'h1000);

        // R8 immediate injection while halted; R12 hold and ignored write
        host_ctl(0, 0);
        host_ctl(1, 0);
        inj_wr = 1; inj_wdata = 32'hCAFE_0001;
        tick();
        idle_inputs();
        chk(inj_valid == 1, "R8", 32'(inj_valid), 1);
        chk(inj_insn == 32'hCAFE_0001, "R8", inj_insn, 32'hCAFE_0001);
        inj_wr = 1; inj_wdata = 32'h1234_5678;
        tick();
        idle_inputs();
        tick();
        chk(inj_valid == 1 && inj_insn == 32'hCAFE_0001, "R12", inj_insn, 32'hCAFE_0001);
        inj_ready = 1;
        tick();
        idle_inputs();
        chk(inj_valid == 0, "R12", 32'(inj_valid), 0);
        tick();
        chk(inj_valid == 0, "R12", 32'(inj_valid), 0);

        // R9 pending while running, offered one cycle after halt
        host_ctl(0, 0);
        inj_wr = 1; inj_wdata = 32'h0000_BEEF;
        tick();
        idle_inputs();
        chk(inj_valid == 0, "R9", 32'(inj_valid), 0);
        tick();
        chk(inj_valid == 0, "R9", 32'(inj_valid), 0);
        host_ctl(1, 0);
        chk(inj_valid == 0, "R9", 32'(inj_valid), 0);
        tick();
        chk(inj_valid == 1 && inj_insn == 32'h0000_BEEF, "R9", inj_insn, 32'h0000_BEEF);
        inj_ready = 1;
        tick();
        idle_inputs();

        // R10 deferral under host reset; R11 falling-edge pulse
        host_ctl(1, 1);
        chk(cpu_rst_pulse == 0, "R11", 32'(cpu_rst_pulse), 0);
        inj_wr = 1; inj_wdata = 32'h7777_0000;
        tick();
        idle_inputs();
        tick();
        chk(inj_valid == 0, "R10", 32'(inj_valid), 0);
        host_ctl(1, 1);
        chk(cpu_rst_pulse == 0, "R11", 32'(cpu_rst_pulse), 0);
        host_ctl(1, 0);
        chk(cpu_rst_pulse == 1, "R11", 32'(cpu_rst_pulse), 1);
        chk(inj_valid == 0, "R10", 32'(inj_valid), 0);
        tick();
        chk(cpu_rst_pulse == 0, "R11", 32'(cpu_rst_pulse), 0);
        chk(inj_valid == 1 && inj_insn == 32'h7777_0000, "R10", inj_insn, 32'h7777_0000);
        inj_ready = 1;
        tick();
        idle_inputs();
        host_ctl(1, 0);
        chk(cpu_rst_pulse == 0, "R11", 32'(cpu_rst_pulse), 0);

        // R13 read of the injection register
        inj_rd = 1;
        tick();
        idle_inputs();
        chk(inj_rd_err == 1, "R13", 32'(inj_rd_err), 1);
        tick();
        chk(inj_rd_err == 0, "R13", 32'(inj_rd_err), 0);

        // R1 reset mid-operation clears everything
        rst_n = 0;
        #2;
        chk({cpu_stall, reason, inj_valid} == '0, "R1", 32'(cpu_stall), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule